// File: doc/BRIEF.md
# Page-Mode DRAM Controller with Refresh Scheduling

This block connects a simple request port to an asynchronous DRAM whose address pins are shared between the row and the column halves of a word address. A request supplies a word address, a direction bit and write data. The controller splits the address into an upper half (row) and a lower half (column). It drives the row strobe, the column strobe, the direction line, the shared address pins and an output enable for the write-data bus.

After an access the row stays open, with the row strobe held low. A later request to the same row then costs only a column strobe. A request to another row closes the open row, waits a configurable precharge time with the row strobe high, and then opens the new row. A free-running timer raises a refresh request once per programmable interval. A pending refresh wins over a waiting access. It closes any open row and then runs a refresh cycle in which the column strobe falls before the row strobe, so the device keeps its own row counter and no data moves.

Top module: `dram_pager`

## Requirements
- R1: While reset is asserted, both strobes are high (inactive), the write-data enable is low and the completion pulse is low.
- R2: For an access, the row half (upper ADDR_PINS bits of the request address) is on the address pins when the row strobe falls. The column half (lower ADDR_PINS bits) is on the pins when the column strobe falls, with the row strobe already low.
- R3: A request to the currently open row issues no new row strobe. Its completion pulse appears on the 2nd rising edge after the edge that accepts it is presented with the request.
- R4: A request with no row open goes through row open, then column strobe, and completes on the 3rd edge.
- R5: A request to a different row raises the row strobe for exactly T_PRE clocks before the new row opens, and completes on the (T_PRE+3)th edge. The row strobe never falls after fewer than T_PRE clocks high.
- R6: The direction line is low (write) only during the column strobe of a write. The write-data enable is high only in that cycle, and the data presented then equals the request's write data.
- R7: For a read, rdata holds the value on the DRAM data input during the column-strobe cycle, and it is valid on the same clock as the completion pulse.
- R8: Refresh requests come once every REF_PERIOD clocks. When the controller is idle with no row open, refresh cycles start exactly REF_PERIOD clocks apart. A refresh cycle lowers the column strobe while the row strobe is high, lowers the row strobe on the next clock, and keeps the direction line high and the data enable low.
- R9: A refresh that is due when a request arrives runs first: the open row is precharged, the refresh runs, a further precharge follows, and only then is the row reopened. The request completes on edge 2*T_PRE+6.
- R10: The completion pulse lasts exactly one clock, and a request still held during that clock is not accepted a second time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Access request, held until ack |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 2*ADDR_PINS | Word address, row in upper half |
| req_wdata | input | DATA_W | Write data |
| ack | output | 1 | One-clock completion pulse |
| rdata | output | DATA_W | Read data, valid with ack |
| dram_addr | output | ADDR_PINS | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Direction line, low for write |
| dram_dq_out | output | DATA_W | Write data toward DRAM |
| dram_dq_oe | output | 1 | Enable for the write-data drivers |
| dram_dq_in | input | DATA_W | Data from DRAM |

## Verification
The checker watches on every cycle that the data enable appears only inside a write's column strobe, that an access column strobe only falls under an already-low row strobe, that a refresh has its column-before-row order, that the row strobe is never high for less than the precharge time before it falls, and that each completion pulse is a single cycle following a column strobe. Only the bench's scenarios show latencies for open-row hits, closed rows and row misses, correct splitting of addresses into row and column, read data integrity against a DRAM model, the spacing between refreshes, and a due refresh winning over a request that arrives at the same edge.

// File: rtl/dpg_pkg.sv
package dpg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_ACT,
    ST_COL,
    ST_RCAS,
    ST_RRAS
  } dpg_state_e;

  typedef enum logic [1:0] {
    GO_ACT,
    GO_REF,
    GO_IDLE
  } dpg_dest_e;

endpackage

// File: rtl/dpg_refresh_timer.sv
module dpg_refresh_timer #(
  parameter int REF_PERIOD = 1560
) (
  input  logic clk,
  input  logic rst_n,
  input  logic take_i,
  output logic pend_o
);
  localparam int CNT_W = (REF_PERIOD > 2) ? $clog2(REF_PERIOD) : 1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pend_q, pend_d;
  logic             tick;

  always_comb begin
    tick   = (cnt_q == CNT_W'(REF_PERIOD - 1));
    cnt_d  = tick ? '0 : cnt_q + CNT_W'(1);
    pend_d = tick | (pend_q & ~take_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/dpg_addr_mux.sv
module dpg_addr_mux #(
  parameter int ADDR_PINS = 10
) (
  input  logic                 sel_col_i,
  input  logic [ADDR_PINS-1:0] row_i,
  input  logic [ADDR_PINS-1:0] col_i,
  output logic [ADDR_PINS-1:0] pins_o
);
  always_comb begin
    pins_o = sel_col_i ? col_i : row_i;
  end
endmodule

// File: rtl/dpg_sequencer.sv
module dpg_sequencer
  import dpg_pkg::*;
#(
  parameter int ADDR_PINS = 10,
  parameter int DATA_W    = 16,
  parameter int T_PRE     = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_i,
  input  logic                   req_we_i,
  input  logic [2*ADDR_PINS-1:0] req_addr_i,
  input  logic [DATA_W-1:0]      req_wdata_i,
  input  logic                   ref_pend_i,
  output logic                   ref_take_o,
  output logic                   ras_n_o,
  output logic                   cas_n_o,
  output logic                   we_n_o,
  output logic                   oe_o,
  output logic                   sel_col_o,
  output logic [ADDR_PINS-1:0]   row_o,
  output logic [ADDR_PINS-1:0]   col_o,
  output logic [DATA_W-1:0]      wdata_o,
  input  logic [DATA_W-1:0]      rdq_i,
  output logic                   ack_o,
  output logic [DATA_W-1:0]      rdata_o
);
  localparam int AW  = 2 * ADDR_PINS;
  localparam int PCW = (T_PRE > 1) ? $clog2(T_PRE) : 1;
  localparam logic [PCW-1:0] PRE_LOAD = PCW'(T_PRE - 1);

  dpg_state_e             state_q, state_d;
  dpg_dest_e              dest_q, dest_d;
  logic [PCW-1:0]         cnt_q, cnt_d;
  logic                   open_q, open_d;
  logic [ADDR_PINS-1:0]   open_row_q, open_row_d;
  logic [ADDR_PINS-1:0]   cur_row_q, cur_col_q;
  logic                   cur_we_q;
  logic [DATA_W-1:0]      cur_wdata_q;
  logic                   ack_q, ack_d;
  logic [DATA_W-1:0]      rdata_q;
  logic                   load, take, row_hit, rd_cap;

  assign row_hit = (req_addr_i[AW-1:ADDR_PINS] == open_row_q);

  // next-state logic
  always_comb begin
    state_d    = state_q;
    dest_d     = dest_q;
    cnt_d      = cnt_q;
    open_d     = open_q;
    open_row_d = open_row_q;
    load       = 1'b0;
    take       = 1'b0;
    ack_d      = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (!ack_q) begin
          if (ref_pend_i) begin
            if (open_q) begin
              state_d = ST_PRE;
              dest_d  = GO_REF;
              cnt_d   = PRE_LOAD;
              open_d  = 1'b0;
            end else begin
              state_d = ST_RCAS;
              take    = 1'b1;
            end
          end else if (req_i) begin
            load = 1'b1;
            if (open_q && row_hit) begin
              state_d = ST_COL;
            end else if (open_q) begin
              state_d = ST_PRE;
              dest_d  = GO_ACT;
              cnt_d   = PRE_LOAD;
              open_d  = 1'b0;
            end else begin
              state_d = ST_ACT;
            end
          end
        end
      end
      ST_PRE: begin
        if (cnt_q == '0) begin
          case (dest_q)
            GO_REF: begin
              state_d = ST_RCAS;
              take    = 1'b1;
            end
            GO_ACT:  state_d = ST_ACT;
            default: state_d = ST_IDLE;
          endcase
        end else begin
          cnt_d = cnt_q - PCW'(1);
        end
      end
      ST_ACT: begin
        state_d    = ST_COL;
        open_d     = 1'b1;
        open_row_d = cur_row_q;
      end
      ST_COL: begin
        state_d = ST_IDLE;
        ack_d   = 1'b1;
      end
      ST_RCAS: state_d = ST_RRAS;
      ST_RRAS: begin
        state_d = ST_PRE;
        dest_d  = GO_IDLE;
        cnt_d   = PRE_LOAD;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      dest_q     <= GO_IDLE;
      cnt_q      <= '0;
      open_q     <= 1'b0;
      open_row_q <= '0;
      ack_q      <= 1'b0;
    end else begin
      state_q    <= state_d;
      dest_q     <= dest_d;
      cnt_q      <= cnt_d;
      open_q     <= open_d;
      open_row_q <= open_row_d;
      ack_q      <= ack_d;
    end
  end

  // request capture, enabled on acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_row_q   <= '0;
      cur_col_q   <= '0;
      cur_we_q    <= 1'b0;
      cur_wdata_q <= '0;
    end else if (load) begin
      cur_row_q   <= req_addr_i[AW-1:ADDR_PINS];
      cur_col_q   <= req_addr_i[ADDR_PINS-1:0];
      cur_we_q    <= req_we_i;
      cur_wdata_q <= req_wdata_i;
    end
  end

  // read data capture, enabled in a read column cycle
  assign rd_cap = (state_q == ST_COL) && !cur_we_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rd_cap) begin
      rdata_q <= rdq_i;
    end
  end

  // strobe decode from registered state
  always_comb begin
    ras_n_o   = !((state_q == ST_ACT) || (state_q == ST_COL) ||
                  (state_q == ST_RRAS) || ((state_q == ST_IDLE) && open_q));
    cas_n_o   = !((state_q == ST_COL) || (state_q == ST_RCAS) ||
                  (state_q == ST_RRAS));
    oe_o      = (state_q == ST_COL) && cur_we_q;
    we_n_o    = !oe_o;
    sel_col_o = (state_q == ST_COL);
  end

  assign ref_take_o = take;
  assign row_o      = cur_row_q;
  assign col_o      = cur_col_q;
  assign wdata_o    = cur_wdata_q;
  assign ack_o      = ack_q;
  assign rdata_o    = rdata_q;
endmodule

// File: rtl/dram_pager.sv
module dram_pager #(
  parameter int ADDR_PINS  = 10,
  parameter int DATA_W     = 16,
  parameter int T_PRE      = 2,
  parameter int REF_PERIOD = 1560
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req,
  input  logic                   req_we,
  input  logic [2*ADDR_PINS-1:0] req_addr,
  input  logic [DATA_W-1:0]      req_wdata,
  output logic                   ack,
  output logic [DATA_W-1:0]      rdata,
  output logic [ADDR_PINS-1:0]   dram_addr,
  output logic                   dram_ras_n,
  output logic                   dram_cas_n,
  output logic                   dram_we_n,
  output logic [DATA_W-1:0]      dram_dq_out,
  output logic                   dram_dq_oe,
  input  logic [DATA_W-1:0]      dram_dq_in
);
  logic                 ref_pend, ref_take, sel_col;
  logic [ADDR_PINS-1:0] row, col;

  dpg_refresh_timer #(.REF_PERIOD(REF_PERIOD)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .take_i (ref_take),
    .pend_o (ref_pend)
  );

  dpg_sequencer #(
    .ADDR_PINS (ADDR_PINS),
    .DATA_W    (DATA_W),
    .T_PRE     (T_PRE)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_i       (req),
    .req_we_i    (req_we),
    .req_addr_i  (req_addr),
    .req_wdata_i (req_wdata),
    .ref_pend_i  (ref_pend),
    .ref_take_o  (ref_take),
    .ras_n_o     (dram_ras_n),
    .cas_n_o     (dram_cas_n),
    .we_n_o      (dram_we_n),
    .oe_o        (dram_dq_oe),
    .sel_col_o   (sel_col),
    .row_o       (row),
    .col_o       (col),
    .wdata_o     (dram_dq_out),
    .rdq_i       (dram_dq_in),
    .ack_o       (ack),
    .rdata_o     (rdata)
  );

  dpg_addr_mux #(.ADDR_PINS(ADDR_PINS)) u_mux (
    .sel_col_i (sel_col),
    .row_i     (row),
    .col_i     (col),
    .pins_o    (dram_addr)
  );
endmodule

// File: rtl/dram_pager_chk.sv
module dram_pager_chk #(
  parameter int T_PRE = 2
) (
  input logic clk,
  input logic rst_n,
  input logic ack,
  input logic dram_ras_n,
  input logic dram_cas_n,
  input logic dram_we_n,
  input logic dram_dq_oe
);
  localparam int HW = $clog2(T_PRE + 1) + 1;

  // consecutive cycles with the row strobe high, saturating; reset counts as precharged
  logic [HW-1:0] hi_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt <= HW'(T_PRE);
    end else if (!dram_ras_n) begin
      hi_cnt <= '0;
    end else if (hi_cnt < HW'(T_PRE)) begin
      hi_cnt <= hi_cnt + HW'(1);
    end
  end

  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |-> (dram_ras_n && dram_cas_n && !dram_dq_oe && !ack));

  a_r2_cas_under_row: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dram_cas_n) && !dram_ras_n) |-> $past(!dram_ras_n));

  a_r5_precharge_min: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_ras_n) |-> (hi_cnt >= HW'(T_PRE)));

  a_r6_drive_in_write: assert property (@(posedge clk) disable iff (!rst_n)
    dram_dq_oe |-> (!dram_cas_n && !dram_ras_n && !dram_we_n));

  a_r7_ack_after_cas: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> $past(!dram_cas_n && !dram_ras_n));

  a_r8_cbr_order: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dram_cas_n) && dram_ras_n) |=>
      (!dram_ras_n && !dram_cas_n && dram_we_n && !dram_dq_oe));

  a_r10_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);
endmodule

bind dram_pager dram_pager_chk #(.T_PRE(T_PRE)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ack        (ack),
  .dram_ras_n (dram_ras_n),
  .dram_cas_n (dram_cas_n),
  .dram_we_n  (dram_we_n),
  .dram_dq_oe (dram_dq_oe)
);

// File: tb/dram_pager_test.sv
module dram_pager_test;
  localparam int CLK_PERIOD = 10;
  localparam int PINS = 4;
  localparam int DW   = 8;
  localparam int TP   = 2;
  localparam int RP   = 400;
  localparam int AW   = 2 * PINS;
  localparam int WD_LIMIT = 20000;

  logic          clk;
  logic          rst_n;
  logic          req, req_we;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic          ack;
  logic [DW-1:0] rdata;
  logic [PINS-1:0] dram_addr;
  logic          dram_ras_n, dram_cas_n, dram_we_n, dram_dq_oe;
  logic [DW-1:0] dram_dq_out, dram_dq_in;

  dram_pager #(.ADDR_PINS(PINS), .DATA_W(DW), .T_PRE(TP), .REF_PERIOD(RP)) uut (
    .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we), .req_addr(req_addr),
    .req_wdata(req_wdata), .ack(ack), .rdata(rdata), .dram_addr(dram_addr),
    .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
    .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  // behavioural DRAM and expectation state
  logic [DW-1:0]   mem    [0:(1<<AW)-1];
  logic [DW-1:0]   shadow [0:(1<<AW)-1];
  logic [PINS-1:0] lrow;
  logic [AW-1:0]   exp_addr;
  logic            exp_we;
  logic [DW-1:0]   exp_wdata;
  bit   prev_ras, prev_cas, prev_ack, cbr_next;
  int   ref_cnt = 0;
  int   ras_falls = 0;
  int   cas_falls = 0;
  int   cbr_cyc = 0;

  assign dram_dq_in = mem[{lrow, dram_addr}];

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    if (!done && cyc >= WD_LIMIT) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, WD_LIMIT);
      finish_run();
    end
  end

  // per-cycle model of the device side
  always @(negedge clk) begin
    if (rst_n) begin
      if (dram_dq_oe)
        chk(!dram_cas_n && !dram_ras_n && !dram_we_n, "R6 enable outside write column",
            {dram_ras_n, dram_cas_n, dram_we_n}, 0);
      if (cbr_next) begin
        chk(!dram_ras_n && !dram_cas_n && dram_we_n && !dram_dq_oe, "R8 refresh order",
            {dram_ras_n, dram_cas_n, dram_we_n, dram_dq_oe}, 4'b0010);
        cbr_next = 1'b0;
      end
      if (prev_ras && !dram_ras_n && dram_cas_n) begin
        lrow = dram_addr;
        ras_falls++;
      end
      if (prev_cas && !dram_cas_n) begin
        if (dram_ras_n) begin
          ref_cnt++;
          cbr_cyc = cyc;
          cbr_next = 1'b1;
        end else begin
          cas_falls++;
          chk({lrow, dram_addr} == exp_addr, "R2 row/column split", {lrow, dram_addr}, exp_addr);
          chk(dram_we_n == !exp_we, "R6 direction line", dram_we_n, !exp_we);
          if (!dram_we_n) begin
            chk(dram_dq_out == exp_wdata, "R6 write data", dram_dq_out, exp_wdata);
            mem[{lrow, dram_addr}] = dram_dq_out;
          end
        end
      end
      if (ack && prev_ack) chk(1'b0, "R10 ack wider than one clock", 1, 0);
      prev_ras = dram_ras_n;
      prev_cas = dram_cas_n;
      prev_ack = ack;
    end else begin
      prev_ras = 1'b1;
      prev_cas = 1'b1;
      prev_ack = 1'b0;
      cbr_next = 1'b0;
    end
  end

  task automatic access(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input int exp_lat, input bit hold, input string tag);
    int lat = 0;
    @(negedge clk);
    exp_addr = a; exp_we = we; exp_wdata = d;
    req = 1'b1; req_we = we; req_addr = a; req_wdata = d;
    do begin
      @(negedge clk);
      lat++;
    end while (!ack && lat < 100);
    chk(ack, {tag, " completion seen"}, ack, 1);
    if (exp_lat > 0) chk(lat == exp_lat, {tag, " latency"}, lat, exp_lat);
    if (!we) chk(rdata == shadow[a], "R7 read data", rdata, shadow[a]);
    else shadow[a] = d;
    if (hold) @(negedge clk);
    req = 1'b0;
    @(negedge clk);
  endtask

  task automatic sync_refresh();
    int n = ref_cnt;
    int w = 0;
    while (ref_cnt == n && w < 2 * RP) begin
      @(negedge clk);
      w++;
    end
    chk(ref_cnt != n, "R8 refresh occurs", ref_cnt, n + 1);
    repeat (TP + 3) @(negedge clk);
  endtask

  initial begin
    int c0, c1, c2, rf, cf, target;
    for (int i = 0; i < (1 << AW); i++) begin
      mem[i]    = DW'(i) ^ 8'hA5;
      shadow[i] = DW'(i) ^ 8'hA5;
    end
    lrow = '0;
    req = 1'b0; req_we = 1'b0; req_addr = '0; req_wdata = '0;
    exp_addr = '0; exp_we = 1'b0; exp_wdata = '0;
    rst_n = 1'b1;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(dram_ras_n && dram_cas_n && !dram_dq_oe && !ack, "R1 reset state",
        {dram_ras_n, dram_cas_n, dram_dq_oe, ack}, 4'b1100);
    rst_n = 1'b1;
    @(negedge clk);
    chk(dram_ras_n && dram_cas_n && !ack, "R1 idle after reset",
        {dram_ras_n, dram_cas_n, ack}, 3'b110);

    // R8: refresh spacing while idle with no row open
    sync_refresh(); c0 = cbr_cyc;
    sync_refresh(); c1 = cbr_cyc;
    sync_refresh(); c2 = cbr_cyc;
    chk(c1 - c0 == RP, "R8 refresh spacing", c1 - c0, RP);
    chk(c2 - c1 == RP, "R8 refresh spacing", c2 - c1, RP);

    // R4 closed row, R3 page hits, R5 misses, R6/R7 data
    access(1'b1, 8'h35, 8'h3C, 3, 1'b0, "R4 closed-row write");
    rf = ras_falls;
    access(1'b1, 8'h3A, 8'hC7, 2, 1'b0, "R3 page-hit write");
    access(1'b0, 8'h35, 8'h00, 2, 1'b0, "R3 page-hit read");
    chk(ras_falls == rf, "R3 no new row strobe", ras_falls, rf);
    access(1'b0, 8'h9C, 8'h00, TP + 3, 1'b0, "R5 row-miss read");
    access(1'b1, 8'h9D, 8'h5A, 2, 1'b0, "R6 write in new row");
    access(1'b0, 8'h9D, 8'h00, 2, 1'b0, "R7 readback");
    access(1'b0, 8'h3A, 8'h00, TP + 3, 1'b0, "R5 row-miss back");
    access(1'b0, 8'hF0, 8'h00, TP + 3, 1'b0, "R7 untouched word");

    // R10: request held through the ack clock is taken once
    cf = cas_falls;
    access(1'b1, 8'hF3, 8'h81, 2, 1'b1, "R10 held request");
    repeat (4) @(negedge clk);
    chk(cas_falls == cf + 1, "R10 single acceptance", cas_falls, cf + 1);
    access(1'b0, 8'hF3, 8'h00, 2, 1'b0, "R10 readback");

    // R9: refresh due at the same edge as a request to the open row
    sync_refresh();
    sync_refresh();
    access(1'b1, 8'h51, 8'h2E, 3, 1'b0, "R4 open row before refresh");
    target = cbr_cyc + RP - 2;
    while (cyc < target) @(negedge clk);
    rf = ref_cnt;
    access(1'b0, 8'h51, 8'h00, 2 * TP + 6, 1'b0, "R9 refresh first");
    chk(ref_cnt == rf + 1, "R9 refresh ran before access", ref_cnt, rf + 1);

    if (!done) begin
      done = 1'b1;
      finish_run();
    end
  end
endmodule